// File: doc/BRIEF.md
# Serial EEPROM Target on a Two-Wire Bus

This block is a two-wire (I2C) target that makes a 256-byte on-chip register array look like a small serial EEPROM. It watches SCL and SDA, which are first synchronized into the system clock domain. From them it decodes START and STOP conditions, the 7-bit device address with its read/write bit, and an 8-bit word address. It then carries out byte writes, page writes and current-address, random and sequential reads. SDA is open-drain. The output value is always low, and an output enable pulls the line down for acknowledge bits and for zero data bits.

Write data is gathered in a four-byte page buffer. The STOP that ends a write starts a timed write cycle, and the buffered bytes reach the array only when that cycle ends. For the length of the cycle the target ignores the bus entirely. A master can therefore poll with address bytes until one is acknowledged. Within a page, the word address advances only in its two low bits, so extra bytes wrap around and overwrite earlier ones. A START that arrives before STOP throws the buffered bytes away.

Top module: `i2c_eeprom_target`

## Requirements
- R1: A byte after START is acknowledged (SDA held low through the ninth SCL pulse) only when its upper seven bits equal the DEV_ADDR parameter (default 0x50). Any other address gets no acknowledge, and the target stays silent until the next START.
- R2: A write consists of the device address with bit 0 = 0, a word address byte and data bytes. Every byte is acknowledged. After STOP and the write cycle, the array holds the data at the word address.
- R3: After each data byte, only word-address bits [1:0] advance (modulo 4) and bits [7:2] stay fixed. A fifth or later byte in the same write overwrites the earlier byte at the same in-page position, and bytes of the neighbouring page are untouched.
- R4: Data reaches the array only when the write cycle completes. A START received before the STOP of a write discards its data bytes, starts no write cycle, and leaves the array unchanged.
- R5: For WR_CYCLES clock cycles after a STOP that ends a write with at least one data byte, the target ignores the bus and never drives SDA, so an address byte gets no acknowledge. After that, a matching address is acknowledged again.
- R6: A random read is a write of the word address, then a repeated START, then the device address with bit 0 = 1. It returns the byte stored at that word address.
- R7: A current-address read (START, then the device address with bit 0 = 1) returns the byte at the internal address counter. The counter holds one past the last byte read, or the in-page position after the last byte written.
- R8: In a read, a master acknowledge on the ninth clock makes the target send the byte at the next address. The address advances over all 8 bits and wraps from 0xFF to 0x00. No acknowledge followed by STOP ends the read, and SDA is released.
- R9: Data bytes are sent MSB first. The target changes its SDA drive only while SCL is low, apart from releasing SDA at START or STOP.
- R10: After reset, SDA is released, the address counter is 0x00, all array bytes are 0x00 and the target is not busy.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | SCL level seen at the pad |
| sda_i | input | 1 | SDA level seen at the pad |
| sda_o | output | 1 | SDA output value, always 0 (open-drain) |
| sda_oe | output | 1 | When 1, the pad pulls SDA low |

## Verification
An address counter that loses track shows up on the very next read byte as data from the wrong location. A page wrap that lets the upper six bits move shows up as a changed byte in the neighbouring page. A pending flag that is not cleared on an aborted write, or a timer that does not release, shows up as a missing acknowledge on the next address byte. A premature commit changes a byte that a later read returns. A drive change while SCL is high is caught within the same bit period, because the SDA line seen by the master then differs from the bit being sent.

// File: rtl/eep_pkg.sv
`timescale 1ns/1ps
package eep_pkg;
  localparam int unsigned AW    = 8;
  localparam int unsigned DW    = 8;
  localparam int unsigned PB    = 2;
  localparam int unsigned LANES = 1 << PB;

  typedef enum logic [3:0] {
    ST_IDLE, ST_DEV, ST_ACK_DEV, ST_WADDR, ST_ACK_WA,
    ST_WDATA, ST_ACK_WD, ST_RDATA, ST_RACK
  } bus_st_t;

  // next write address: only the in-page bits move
  function automatic logic [AW-1:0] page_step(input logic [AW-1:0] a);
    logic [PB-1:0] lo;
    lo = a[PB-1:0] + PB'(1);
    return {a[AW-1:PB], lo};
  endfunction

  // next read address: whole counter moves, wrapping at the top
  function automatic logic [AW-1:0] seq_step(input logic [AW-1:0] a);
    return a + AW'(1);
  endfunction
endpackage

// File: rtl/i2c_line_sync.sv
`timescale 1ns/1ps
module i2c_line_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic sda_lvl,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_evt,
  output logic stop_evt
);
  logic [STAGES-1:0] scl_q, sda_q;
  logic scl_d, sda_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_q <= '1;
      sda_q <= '1;
      scl_d <= 1'b1;
      sda_d <= 1'b1;
    end else begin
      scl_q <= {scl_q[STAGES-2:0], scl_i};
      sda_q <= {sda_q[STAGES-2:0], sda_i};
      scl_d <= scl_q[STAGES-1];
      sda_d <= sda_q[STAGES-1];
    end
  end

  logic scl_s;
  assign scl_s     = scl_q[STAGES-1];
  assign sda_lvl   = sda_q[STAGES-1];
  assign scl_rise  = scl_s & ~scl_d;
  assign scl_fall  = ~scl_s & scl_d;
  assign start_evt = scl_s & scl_d & sda_d & ~sda_lvl;
  assign stop_evt  = scl_s & scl_d & ~sda_d & sda_lvl;
endmodule

// File: rtl/eep_busy_timer.sv
`timescale 1ns/1ps
module eep_busy_timer #(
  parameter int unsigned CYCLES = 1000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic load,
  output logic busy,
  output logic done
);
  localparam int unsigned CW = $clog2(CYCLES + 1);
  logic [CW-1:0] cnt;

  assign done = busy && (cnt == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy <= 1'b0;
      cnt  <= '0;
    end else if (load) begin
      busy <= 1'b1;
      cnt  <= CW'(CYCLES - 1);
    end else if (done) begin
      busy <= 1'b0;
    end else if (busy) begin
      cnt <= cnt - CW'(1);
    end
  end

  AST_BUSY_ARMS: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> busy); // R5
endmodule

// File: rtl/eep_page_buf.sv
`timescale 1ns/1ps
module eep_page_buf #(
  parameter int unsigned LANES = 4,
  parameter int unsigned DW    = 8,
  localparam int unsigned LW   = $clog2(LANES)
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      clr,
  input  logic                      we,
  input  logic [LW-1:0]             lane,
  input  logic [DW-1:0]             din,
  output logic [LANES-1:0][DW-1:0]  data,
  output logic [LANES-1:0]          valid
);
  for (genvar g = 0; g < LANES; g++) begin : g_lane
    logic hit;
    assign hit = we && (lane == LW'(g));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        data[g]  <= '0;
        valid[g] <= 1'b0;
      end else if (clr) begin
        valid[g] <= 1'b0;
      end else if (hit) begin
        data[g]  <= din;
        valid[g] <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/eep_store.sv
`timescale 1ns/1ps
module eep_store #(
  parameter int unsigned AW    = 8,
  parameter int unsigned DW    = 8,
  parameter int unsigned LANES = 4,
  localparam int unsigned LW    = $clog2(LANES),
  localparam int unsigned DEPTH = 1 << AW
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      commit,
  input  logic [AW-LW-1:0]          base,
  input  logic [LANES-1:0][DW-1:0]  pdata,
  input  logic [LANES-1:0]          pvalid,
  input  logic [AW-1:0]             raddr,
  output logic [DW-1:0]             rdata
);
  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
    end else if (commit) begin
      for (int l = 0; l < LANES; l++)
        if (pvalid[l]) mem[{base, LW'(l)}] <= pdata[l];
    end
  end

  assign rdata = mem[raddr];
endmodule

// File: rtl/i2c_eeprom_target.sv
`timescale 1ns/1ps
module i2c_eeprom_target
  import eep_pkg::*;
#(
  parameter logic [6:0]  DEV_ADDR    = 7'h50,
  parameter int unsigned WR_CYCLES   = 1000,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic sda_o,
  output logic sda_oe
);
  // synchronized bus events
  logic sda_lvl, scl_rise, scl_fall, start_evt, stop_evt;

  i2c_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i),
    .sda_lvl(sda_lvl), .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_evt(start_evt), .stop_evt(stop_evt)
  );

  bus_st_t         st;
  logic [3:0]      bitcnt;
  logic [DW-1:0]   rx_sh, tx_sh;
  logic [AW-1:0]   addr;
  logic            rw, mack, pending, oe;
  logic            busy, commit;
  logic [DW-1:0]   rd_byte;
  logic [LANES-1:0][DW-1:0] pg_data;
  logic [LANES-1:0]         pg_valid;

  // named internal events
  logic byte_done, wbyte_evt, busy_load, abort_evt, buf_clr;
  assign byte_done = scl_fall && (bitcnt == 4'd8);
  assign wbyte_evt = !busy && !start_evt && !stop_evt && (st == ST_WDATA) && byte_done;
  assign busy_load = !busy && stop_evt && pending;
  assign abort_evt = !busy && start_evt && pending;
  assign buf_clr   = commit || abort_evt;

  eep_busy_timer #(.CYCLES(WR_CYCLES)) u_timer (
    .clk(clk), .rst_n(rst_n), .load(busy_load), .busy(busy), .done(commit)
  );

  eep_page_buf #(.LANES(LANES), .DW(DW)) u_pbuf (
    .clk(clk), .rst_n(rst_n), .clr(buf_clr), .we(wbyte_evt),
    .lane(addr[PB-1:0]), .din(rx_sh), .data(pg_data), .valid(pg_valid)
  );

  eep_store #(.AW(AW), .DW(DW), .LANES(LANES)) u_store (
    .clk(clk), .rst_n(rst_n), .commit(commit), .base(addr[AW-1:PB]),
    .pdata(pg_data), .pvalid(pg_valid), .raddr(addr), .rdata(rd_byte)
  );

  assign sda_o  = 1'b0;
  assign sda_oe = oe;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st      <= ST_IDLE;
      bitcnt  <= '0;
      rx_sh   <= '0;
      tx_sh   <= '0;
      addr    <= '0;
      rw      <= 1'b0;
      mack    <= 1'b0;
      pending <= 1'b0;
      oe      <= 1'b0;
    end else begin
      if (commit) pending <= 1'b0;
      if (busy) begin
        st <= ST_IDLE;
        oe <= 1'b0;
      end else if (start_evt) begin
        st      <= ST_DEV;
        bitcnt  <= '0;
        oe      <= 1'b0;
        pending <= 1'b0;
      end else if (stop_evt) begin
        st <= ST_IDLE;
        oe <= 1'b0;
      end else if (scl_rise) begin
        unique case (st)
          ST_DEV, ST_WADDR, ST_WDATA: begin
            rx_sh  <= {rx_sh[DW-2:0], sda_lvl};
            bitcnt <= bitcnt + 4'd1;
          end
          ST_RDATA: bitcnt <= bitcnt + 4'd1;
          ST_RACK:  mack   <= !sda_lvl;
          default: ;
        endcase
      end else if (scl_fall) begin
        unique case (st)
          ST_DEV: if (byte_done) begin
            if (rx_sh[7:1] == DEV_ADDR) begin
              oe <= 1'b1;
              rw <= rx_sh[0];
              st <= ST_ACK_DEV;
            end else begin
              st <= ST_IDLE;
            end
          end
          ST_ACK_DEV, ST_RACK: begin
            if ((st == ST_ACK_DEV && rw) || (st == ST_RACK && mack)) begin
              oe     <= !rd_byte[DW-1];
              tx_sh  <= {rd_byte[DW-2:0], 1'b0};
              bitcnt <= '0;
              st     <= ST_RDATA;
            end else if (st == ST_ACK_DEV) begin
              oe     <= 1'b0;
              bitcnt <= '0;
              st     <= ST_WADDR;
            end else begin
              oe <= 1'b0;
              st <= ST_IDLE;
            end
          end
          ST_WADDR: if (byte_done) begin
            addr <= rx_sh;
            oe   <= 1'b1;
            st   <= ST_ACK_WA;
          end
          ST_ACK_WA, ST_ACK_WD: begin
            oe     <= 1'b0;
            bitcnt <= '0;
            st     <= ST_WDATA;
          end
          ST_WDATA: if (byte_done) begin
            addr    <= page_step(addr);
            pending <= 1'b1;
            oe      <= 1'b1;
            st      <= ST_ACK_WD;
          end
          ST_RDATA: begin
            if (byte_done) begin
              oe   <= 1'b0;
              addr <= seq_step(addr);
              st   <= ST_RACK;
            end else begin
              oe    <= !tx_sh[DW-1];
              tx_sh <= {tx_sh[DW-2:0], 1'b0};
            end
          end
          default: ;
        endcase
      end
    end
  end

  AST_SILENT_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !sda_oe); // R5
  AST_OE_ON_EVENT: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(sda_oe) |-> $past(scl_fall || start_evt || stop_evt)); // R9
  AST_PAGE_HIGH_FIXED: assert property (@(posedge clk) disable iff (!rst_n)
    wbyte_evt |=> addr[AW-1:PB] == $past(addr[AW-1:PB])); // R3
  AST_COMMIT_NEEDS_PENDING: assert property (@(posedge clk) disable iff (!rst_n)
    commit |-> pending); // R4
  AST_DRAINED_AFTER_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> !pending); // R4
endmodule

// File: tb/i2c_eeprom_target_tb.sv
`timescale 1ns/1ps
module i2c_eeprom_target_tb;
  localparam int WR = 600;
  localparam int Q  = 6;
  localparam logic [7:0] DEV_W = 8'hA0;
  localparam logic [7:0] DEV_R = 8'hA1;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic scl = 1'b1;
  logic sda_m = 1'b1;
  logic sda_o, sda_oe;
  wire  sda_line = sda_m & ~sda_oe;
  int n_run = 0, n_fail = 0, viol = 0;

  always #5 clk = ~clk;

  i2c_eeprom_target #(.DEV_ADDR(7'h50), .WR_CYCLES(WR)) u_dut (
    .clk(clk), .rst_n(rst_n), .scl_i(scl), .sda_i(sda_line),
    .sda_o(sda_o), .sda_oe(sda_oe)
  );

  task automatic tick(int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic chk(string tag, logic [7:0] act, logic [7:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%02h expected=%02h", tag, act, exp);
    end
  endtask

  // drive changes only while SCL is high must not come from the target (R9)
  logic prev_oe = 1'b0;
  always begin
    @(posedge clk); #2;
    if (rst_n && sda_oe !== prev_oe && scl) viol++;
    prev_oe = sda_oe;
  end

  task automatic m_start();
    sda_m = 1'b1; tick(Q); scl = 1'b1; tick(Q);
    sda_m = 1'b0; tick(Q); scl = 1'b0; tick(Q);
  endtask

  task automatic m_stop();
    sda_m = 1'b0; tick(Q); scl = 1'b1; tick(Q); sda_m = 1'b1; tick(2*Q);
  endtask

  task automatic send_bit(logic b);
    sda_m = b; tick(Q); scl = 1'b1; tick(2*Q); scl = 1'b0; tick(Q);
  endtask

  task automatic recv_bit(output logic v);
    sda_m = 1'b1; tick(Q); scl = 1'b1; tick(Q); v = sda_line; tick(Q);
    scl = 1'b0; tick(Q);
  endtask

  task automatic wr_byte(logic [7:0] b, output logic ack);
    logic v;
    for (int i = 7; i >= 0; i--) send_bit(b[i]);
    recv_bit(v);
    ack = !v;
  endtask

  task automatic rd_byte(logic give_ack, output logic [7:0] b);
    logic v;
    for (int i = 7; i >= 0; i--) begin recv_bit(v); b[i] = v; end
    send_bit(!give_ack);
  endtask

  // write a series of bytes from a word address, then STOP and wait out the cycle
  task automatic do_write(logic [7:0] a, logic [7:0] d [], string tag);
    logic ack;
    m_start();
    wr_byte(DEV_W, ack); chk({tag, " dev ack"}, {7'd0, ack}, 8'd1);
    wr_byte(a, ack);     chk({tag, " addr ack"}, {7'd0, ack}, 8'd1);
    foreach (d[i]) begin
      wr_byte(d[i], ack); chk({tag, " data ack"}, {7'd0, ack}, 8'd1);
    end
    m_stop();
    tick(WR + 40);
  endtask

  // random read setup: dummy write of address, repeated START, read address
  task automatic open_read(logic [7:0] a, string tag);
    logic ack;
    m_start();
    wr_byte(DEV_W, ack);
    wr_byte(a, ack);
    m_start();
    wr_byte(DEV_R, ack); chk({tag, " read dev ack"}, {7'd0, ack}, 8'd1);
  endtask

  task automatic t_reset();
    logic ack; logic [7:0] b;
    chk("R10 sda released after reset", {7'd0, sda_oe}, 8'd0);
    m_start();
    wr_byte(DEV_R, ack); chk("R10 dev ack", {7'd0, ack}, 8'd1);
    rd_byte(1'b1, b); chk("R10 byte at counter 0", b, 8'h00);
    rd_byte(1'b0, b); chk("R10 byte at 1", b, 8'h00);
    m_stop();
  endtask

  task automatic t_bad_addr();
    logic ack;
    m_start();
    wr_byte(8'hA2, ack); chk("R1 other address not acked", {7'd0, ack}, 8'd0);
    send_bit(1'b0); send_bit(1'b1);
    m_stop();
    m_start();
    wr_byte(DEV_W, ack); chk("R1 own address acked", {7'd0, ack}, 8'd1);
    m_stop();
  endtask

  task automatic t_byte_and_current();
    logic ack; logic [7:0] b;
    do_write(8'h10, '{8'hA5}, "R2");
    do_write(8'h11, '{8'h5A}, "R2");
    open_read(8'h10, "R6");
    rd_byte(1'b0, b); chk("R6 random read 0x10", b, 8'hA5);
    m_stop();
    m_start();
    wr_byte(DEV_R, ack); chk("R7 dev ack", {7'd0, ack}, 8'd1);
    rd_byte(1'b0, b); chk("R7 current address read", b, 8'h5A);
    m_stop();
  endtask

  task automatic t_busy();
    logic ack; logic [7:0] b;
    m_start();
    wr_byte(DEV_W, ack); wr_byte(8'h40, ack); wr_byte(8'h99, ack);
    m_stop();
    m_start();
    wr_byte(DEV_W, ack); chk("R5 no ack while busy", {7'd0, ack}, 8'd0);
    m_stop();
    tick(WR);
    m_start();
    wr_byte(DEV_W, ack); chk("R5 ack after write cycle", {7'd0, ack}, 8'd1);
    m_stop();
    open_read(8'h40, "R2");
    rd_byte(1'b0, b); chk("R2 polled write stored", b, 8'h99);
    m_stop();
  endtask

  task automatic t_page();
    logic [7:0] b;
    logic [7:0] exp [5] = '{8'h33, 8'h44, 8'h55, 8'h66, 8'h00};
    do_write(8'h22, '{8'h11, 8'h22, 8'h33, 8'h44, 8'h55, 8'h66}, "R3");
    open_read(8'h20, "R3");
    for (int i = 0; i < 5; i++) begin
      rd_byte(i != 4, b); chk("R3 page wrap contents", b, exp[i]);
    end
    m_stop();
  endtask

  task automatic t_abort();
    logic ack; logic [7:0] b;
    m_start();
    wr_byte(DEV_W, ack); wr_byte(8'h30, ack); wr_byte(8'h77, ack);
    m_start();
    m_stop();
    m_start();
    wr_byte(DEV_W, ack); chk("R4 no write cycle after abort", {7'd0, ack}, 8'd1);
    m_stop();
    open_read(8'h30, "R4");
    rd_byte(1'b0, b); chk("R4 aborted byte not stored", b, 8'h00);
    m_stop();
  endtask

  task automatic t_wrap();
    logic [7:0] b;
    do_write(8'hFF, '{8'hEE}, "R8");
    do_write(8'h00, '{8'h01}, "R8");
    open_read(8'hFF, "R8");
    rd_byte(1'b1, b); chk("R8 read at 0xFF", b, 8'hEE);
    rd_byte(1'b0, b); chk("R8 wrap to 0x00", b, 8'h01);
    m_stop();
    tick(2*Q);
    chk("R8 sda released after read", {7'd0, sda_oe}, 8'd0);
  endtask

  initial begin
    tick(5);
    rst_n = 1'b1;
    tick(5);
    t_reset();
    t_bad_addr();
    t_byte_and_current();
    t_busy();
    t_page();
    t_abort();
    t_wrap();
    chk("R9 drive changed while SCL high", viol[7:0], 8'd0);
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    tick(150000);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule